// File: doc/BRIEF.md
# Cascadable Serial DAC Word Loader

This block is the digital front end of a 16-bit serial-input converter. A frame begins when the active-low frame select goes low. The block then shifts serial data, most significant bit first, into an input shift register on each falling edge of the serial clock. A separate output latch holds the code presented to the converter. That latch is loaded from the shift register on a falling edge of the load strobe, and an active-low clear input forces it to zero.

A mode input selects between two ways of working. In standalone mode, a bit counter shuts off the serial clock once one word has been accepted. In cascade mode, every clock edge reaches the register for as long as the frame select stays low. Bits pushed past the register's top then leave on the serial output and feed the next device in the chain.

All inputs are sampled by a fast system clock, so serial clock and strobe edges are found by comparing each input with its value one system cycle earlier.

Top module: `serial_dac_front`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dac_code` is 0 and `sdout` is 0.
- R2: On each falling `sclk` edge while `sync_n` is low, the register shifts left and takes `sdin` into bit 0. After 16 such edges and a load, `dac_code` bit 15 holds the first bit sent.
- R3: While `sync_n` is high, `sclk` edges leave the shift register unchanged.
- R4: With `chain_en` low, only the first 16 falling edges of a frame are accepted, later edges are ignored, and `sdout` stays 0.
- R5: With `chain_en` high, `sdout` shows bit 15 of the shift register and changes only after a falling `sclk` edge. N chained devices loaded with 16×N edges each hold their own word, and the last device's word is sent first.
- R6: Two ways of ending a frame give the same result. In the first, `sync_n` is raised while `sclk` keeps running. In the second, a burst of exactly 16×N pulses is sent and `sync_n` is raised some time later.
- R7: A falling edge of `ldac_n` copies the shift register into `dac_code`. A shared `ldac_n` updates every device in a chain in the same cycle.
- R8: While `clr_n` is low, `dac_code` is 0, even when `ldac_n` falls at the same time.
- R9: A clear does not touch the shift register, so a later load still delivers the word that was shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Power-on reset, active low |
| chain_en | input | 1 | 1 selects cascade mode, 0 selects standalone mode |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Load strobe; a falling edge loads the output latch |
| clr_n | input | 1 | Asynchronous clear of the output latch, active low |
| dac_code | output | 16 | Latched code driven to the converter |
| sdout | output | 1 | Serial data out, cascade mode only |

## Verification
Two of the block's functions can land on the same cycle: the clear and the load strobe both write the output latch. The bench lowers `clr_n` and `ldac_n` together right after the registers have been loaded with non-zero words, and expects every latch to read 0. It then raises `clr_n` and sends a new strobe on its own, and expects the earlier words back, which shows that the clear never reached the shift registers. Random frames in both modes, with extra clocks in standalone mode, are compared against words worked out by bench functions.

// File: rtl/serial_dac_front.sv
module serial_dac_front #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chain_en,
  input  logic         sync_n,
  input  logic         sclk,
  input  logic         sdin,
  input  logic         ldac_n,
  input  logic         clr_n,
  output logic [W-1:0] dac_code,
  output logic         sdout
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          full;
  logic          sclk_q, ldac_q;

  wire sclk_fall = sclk_q & ~sclk;
  wire ldac_fall = ldac_q & ~ldac_n;
  wire take      = sclk_fall & ~sync_n & (chain_en | ~full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      ldac_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      ldac_q <= ldac_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      full  <= 1'b0;
    end else if (sync_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (take) begin
      shreg <= {shreg[W-2:0], sdin};
      cnt   <= cnt + 1'b1;
      if (cnt == CW'(W-1)) full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n || !clr_n) dac_code <= '0;
    else if (ldac_fall)   dac_code <= shreg;
  end

  assign sdout = chain_en & shreg[W-1];

  a_r3_sync_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |=> shreg == $past(shreg));

  a_r4_standalone_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en && full && !sync_n) |=> shreg == $past(shreg));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !sync_n && sclk_fall) |=> shreg == {$past(shreg[W-2:0]), $past(sdin)});

  a_r5_sdout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !sclk_fall) |=> (!chain_en || sdout == $past(sdout)));

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && clr_n) |=> (!clr_n || dac_code == $past(shreg)));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == '0);
endmodule

// File: tb/sim_serial_dac_front.sv
module sim_serial_dac_front;
  logic clk = 0, rst_n = 0, chain_en = 1, sync_n = 1, sclk = 1;
  logic sdin = 0, ldac_n = 1, clr_n = 1;
  logic [15:0] c0, c1, c2;
  logic s0, s1, s2;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  serial_dac_front u0 (.clk(clk), .rst_n(rst_n), .chain_en(chain_en), .sync_n(sync_n),
    .sclk(sclk), .sdin(sdin), .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(c0), .sdout(s0));
  serial_dac_front u1 (.clk(clk), .rst_n(rst_n), .chain_en(chain_en), .sync_n(sync_n),
    .sclk(sclk), .sdin(s0), .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(c1), .sdout(s1));
  serial_dac_front u2 (.clk(clk), .rst_n(rst_n), .chain_en(chain_en), .sync_n(sync_n),
    .sclk(sclk), .sdin(s1), .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(c2), .sdout(s2));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdin = b; sclk = 1; waitc(2);
    sclk = 0; waitc(2);
    sclk = 1;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) pulse(w[i]);
  endtask

  task automatic load();
    ldac_n = 0; waitc(2); ldac_n = 1; waitc(1);
  endtask

  function automatic logic [15:0] standalone_expect(input logic [15:0] w);
    return w;
  endfunction

  function automatic logic [15:0] chain_sdout(input logic [15:0] w);
    return {15'd0, w[15]};
  endfunction

  task automatic chain_frame(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                             input bit continuous);
    waitc(1); sync_n = 0; waitc(2);
    send_word(c); send_word(b); send_word(a);
    if (continuous) begin
      sdin = 0; sclk = 1; waitc(1); sync_n = 1; waitc(1);
      for (int i = 0; i < 3; i++) pulse(1'b1);
    end else begin
      waitc(6); sync_n = 1;
    end
    waitc(2);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a, b, c, w;
    void'($urandom(32'd1234));
    waitc(3);
    chk("R1 code in reset", c0, 16'h0);
    chk("R1 sdout in reset", {15'd0, s0}, 16'h0);
    rst_n = 1; waitc(2);
    chk("R1 code after reset", c0, 16'h0);

    // R5 / R7: burst chain frame
    chain_frame(16'hA5C3, 16'h1234, 16'hFEDC, 0);
    chk("R5 sdout of first device", {15'd0, s0}, chain_sdout(16'hA5C3));
    load();
    chk("R7 u0 word", c0, 16'hA5C3);
    chk("R7 u1 word", c1, 16'h1234);
    chk("R5 u2 word", c2, 16'hFEDC);

    // R6: continuous clock ending gives same words
    chain_frame(16'hA5C3, 16'h1234, 16'hFEDC, 1);
    load();
    chk("R6 u0 continuous", c0, 16'hA5C3);
    chk("R6 u1 continuous", c1, 16'h1234);
    chk("R6 u2 continuous", c2, 16'hFEDC);

    // R3: clocks with sync high change nothing
    for (int i = 0; i < 16; i++) pulse(1'b0);
    load();
    chk("R3 u0 unchanged", c0, 16'hA5C3);
    chk("R3 u2 unchanged", c2, 16'hFEDC);

    // R8 / R9: clear and load together
    clr_n = 0; ldac_n = 0; waitc(2);
    chk("R8 u0 cleared", c0, 16'h0);
    chk("R8 u1 cleared", c1, 16'h0);
    ldac_n = 1; clr_n = 1; waitc(2);
    chk("R8 stays zero after clear", c0, 16'h0);
    load();
    chk("R9 u0 word kept", c0, 16'hA5C3);
    chk("R9 u1 word kept", c1, 16'h1234);

    // R4: standalone with extra clocks
    chain_en = 0;
    waitc(1); sync_n = 0; waitc(2);
    send_word(16'h8001);
    for (int i = 0; i < 5; i++) pulse(1'b0);
    chk("R4 sdout low standalone", {15'd0, s0}, 16'h0);
    sync_n = 1; waitc(2);
    load();
    chk("R4 u0 first word only", c0, standalone_expect(16'h8001));
    chk("R4 u1 fed zeros", c1, 16'h0);

    // random mix
    for (int k = 0; k < 12; k++) begin
      if ($urandom % 2) begin
        chain_en = 1;
        a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
        chain_frame(a, b, c, bit'($urandom % 2));
        load();
        chk("R5 random u0", c0, a);
        chk("R5 random u1", c1, b);
        chk("R6 random u2", c2, c);
      end else begin
        chain_en = 0;
        w = 16'($urandom);
        waitc(1); sync_n = 0; waitc(2);
        send_word(w);
        for (int i = 0; i < int'($urandom % 8); i++) pulse(1'($urandom));
        sync_n = 1; waitc(2);
        load();
        chk("R2 random standalone", c0, standalone_expect(w));
        chk("R4 random sdout", {15'd0, s0}, 16'h0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule